// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Feedback-Gated Turn-On

This block sits between a PWM source and the two gate drivers of a synchronous-buck half-bridge. The PWM input selects the phase. When it is high, the upper switch conducts. When it is low, the lower switch conducts, but only in synchronous mode. A separate gate control drives each switch.

The block does not use a fixed dead time. Each turn-on waits for a sensed signal that shows the opposite path has really gone off. The upper switch waits for the sensed lower-gate level to read low. The lower switch waits for the sensed switch-node level to read low. A minimum number of all-off cycles is enforced on every handover.

Three control inputs shape the behaviour. An enable input parks both gates off. A mode input selects synchronous or diode-rectified operation. An active-low clamp input turns the lower switch on and the upper switch off, whatever the other inputs say; it is meant for an overvoltage protection circuit.

If a feedback line never confirms, the pending turn-on is dropped after a bounded wait. A sticky fault then keeps both gates off until reset. All six inputs are asynchronous and are synchronized inside the block. The interface is plain level-sensitive control; it has no data stream and no back-pressure.

Top module: `hb_gate_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, and on the cycle after it, `hs_gate_o`, `ls_gate_o` and `fault_o` are all 0.
- R2: When `clamp_n_i` is held at 0, then from the third clock edge onward `ls_gate_o`=1 and `hs_gate_o`=0, whatever the values of PWM, enable, mode or the fault flag.
- R3: When `clamp_n_i`=1 and `en_i`=0 are held, both gate outputs are 0 from the third clock edge onward.
- R4: When `sync_i`=0 (diode mode) is held and the clamp is not active, `ls_gate_o` stays 0, and `hs_gate_o` follows the effective PWM level once the feedback settles.
- R5: When `sync_i`=1 and `en_i`=1, `ls_gate_o` turns on while the effective PWM is low, and `hs_gate_o` turns on while it is high; the two are complementary apart from the handover gaps.
- R6: `hs_gate_o` rises only after the synchronized `ls_fb_i` has read 0; while `ls_fb_i` stays 1, the upper gate stays off.
- R7: `ls_gate_o` rises in normal operation only after the synchronized `sw_fb_i` has read 0; while `sw_fb_i` stays 1, the lower gate stays off.
- R8: Between one gate turning off and the other turning on in normal operation, both gates are off for at least `MIN_GAP` cycles. With both feedback lines already low, the gap is exactly `MIN_GAP` cycles.
- R9: With `PWM_INVERT`=0 the effective PWM equals `pwm_i`; with `PWM_INVERT`=1 it equals `~pwm_i`.
- R10: If the awaited feedback does not read 0 within `TIMEOUT` cycles of a wait, `fault_o` goes to 1 and both gates go off. `fault_o` then stays 1 and the gates stay off, except for the clamp, until reset.
- R11: `hs_gate_o` and `ls_gate_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_i | input | 1 | Asynchronous PWM phase command |
| en_i | input | 1 | Asynchronous enable; 0 turns both gates off |
| sync_i | input | 1 | Asynchronous mode: 1 synchronous rectification, 0 lower switch never used |
| clamp_n_i | input | 1 | Asynchronous active-low clamp override |
| ls_fb_i | input | 1 | Sensed lower-gate level, 1 = still on |
| sw_fb_i | input | 1 | Sensed switch-node level, 1 = still high |
| hs_gate_o | output | 1 | Upper switch gate command |
| ls_gate_o | output | 1 | Lower switch gate command |
| fault_o | output | 1 | Sticky feedback-timeout flag |

## Verification
The hardest situation to reach from the ports is a wait that stalls long enough to time out. A plausible PWM stream always brings the feedback low quickly, so a stall never happens by itself. Directed sequences therefore hold one feedback line high across a handover. Some are shorter than the limit, to show the gate waits and then proceeds. One runs past the limit, to show the fault latches and stays latched through later PWM edges and a clamp pulse. The random phase mixes enable, mode and clamp changes with rare feedback stalls, so the override priorities are also reached from states that directed cases do not visit.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HIGH    = 3'd1,
    ST_HOLD_HI = 3'd2,
    ST_LOW     = 3'd3,
    ST_HOLD_LO = 3'd4,
    ST_CLAMP   = 3'd5
  } hbg_state_e;

  localparam int IN_W       = 6;
  localparam int IX_PWM     = 0;
  localparam int IX_EN      = 1;
  localparam int IX_SYNC    = 2;
  localparam int IX_CLAMP_N = 3;
  localparam int IX_LS_FB   = 4;
  localparam int IX_SW_FB   = 5;

  localparam logic [IN_W-1:0] IN_RESET = 6'b00_1000;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/hbg_wait_timer.sv
module hbg_wait_timer #(
  parameter int MIN_GAP = 3,
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic gap_done_o,
  output logic expired_o
);

  localparam int             CW       = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0]  GAP_LAST = CW'(MIN_GAP - 1);
  localparam logic [CW-1:0]  TMO_LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (run_i && !expired_o)    cnt_q <= cnt_q + 1'b1;
  end

  assign gap_done_o = (cnt_q >= GAP_LAST);
  assign expired_o  = (cnt_q >= TMO_LAST);

  p_cnt_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TMO_LAST);

endmodule

// File: rtl/hbg_fsm.sv
module hbg_fsm
  import hbg_pkg::*;
#(
  parameter int MIN_GAP = 3,
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic en_i,
  input  logic sync_i,
  input  logic clamp_n_i,
  input  logic ls_fb_i,
  input  logic sw_fb_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic fault_o
);

  hbg_state_e state_q, state_d;
  logic       fault_q;
  logic       timeout_hit;
  logic       gap_done, expired;
  logic       in_wait;

  assign in_wait = (state_q == ST_HOLD_HI) || (state_q == ST_HOLD_LO);

  hbg_wait_timer #(
    .MIN_GAP (MIN_GAP),
    .TIMEOUT (TIMEOUT)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (state_d != state_q),
    .run_i      (in_wait),
    .gap_done_o (gap_done),
    .expired_o  (expired)
  );

  always_comb begin
    state_d     = state_q;
    timeout_hit = 1'b0;
    if (!clamp_n_i) begin
      state_d = ST_CLAMP;
    end else if (fault_q || !en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_CLAMP: state_d = ST_IDLE;
        ST_IDLE: begin
          if (pwm_i)       state_d = ST_HOLD_HI;
          else if (sync_i) state_d = ST_HOLD_LO;
        end
        ST_HOLD_HI: begin
          if (!pwm_i)                  state_d = sync_i ? ST_HOLD_LO : ST_IDLE;
          else if (gap_done && !ls_fb_i) state_d = ST_HIGH;
          else if (expired) begin
            timeout_hit = 1'b1;
            state_d     = ST_IDLE;
          end
        end
        ST_HIGH: begin
          if (!pwm_i) state_d = sync_i ? ST_HOLD_LO : ST_IDLE;
        end
        ST_HOLD_LO: begin
          if (pwm_i)                     state_d = ST_HOLD_HI;
          else if (!sync_i)              state_d = ST_IDLE;
          else if (gap_done && !sw_fb_i) state_d = ST_LOW;
          else if (expired) begin
            timeout_hit = 1'b1;
            state_d     = ST_IDLE;
          end
        end
        ST_LOW: begin
          if (pwm_i)        state_d = ST_HOLD_HI;
          else if (!sync_i) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_q | timeout_hit;
    end
  end

  assign hs_gate_o = (state_q == ST_HIGH);
  assign ls_gate_o = (state_q == ST_LOW) || (state_q == ST_CLAMP);
  assign fault_o   = fault_q;

  // Run length of all-off cycles, kept only to check the handover gap.
  localparam int            OW      = $clog2(MIN_GAP + 2);
  localparam logic [OW-1:0] OFF_SAT = OW'(MIN_GAP + 1);
  logic [OW-1:0] off_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        off_run_q <= '0;
    else if (hs_gate_o || ls_gate_o)   off_run_q <= '0;
    else if (off_run_q != OFF_SAT)     off_run_q <= off_run_q + 1'b1;
  end

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate_o && ls_gate_o));

  p_clamp_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_n_i |=> (ls_gate_o && !hs_gate_o));

  p_disable_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_n_i && !en_i) |=> (!hs_gate_o && !ls_gate_o));

  p_diode_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_n_i && !sync_i) |=> !ls_gate_o);

  p_hs_after_fb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> $past(!ls_fb_i));

  p_ls_after_fb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOW && $past(state_q) != ST_LOW) |-> $past(!sw_fb_i));

  p_min_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> (off_run_q >= OW'(MIN_GAP)));

  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && clamp_n_i) |=> !hs_gate_o);

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hbg_pkg::*;
#(
  parameter bit PWM_INVERT  = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP     = 3,
  parameter int TIMEOUT     = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic en_i,
  input  logic sync_i,
  input  logic clamp_n_i,
  input  logic ls_fb_i,
  input  logic sw_fb_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic fault_o
);

  logic [IN_W-1:0] raw_in, syn_in;
  logic            pwm_eff;

  always_comb begin
    raw_in              = '0;
    raw_in[IX_PWM]      = pwm_i;
    raw_in[IX_EN]       = en_i;
    raw_in[IX_SYNC]     = sync_i;
    raw_in[IX_CLAMP_N]  = clamp_n_i;
    raw_in[IX_LS_FB]    = ls_fb_i;
    raw_in[IX_SW_FB]    = sw_fb_i;
  end

  hbg_sync #(
    .W       (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IN_RESET)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  if (PWM_INVERT) begin : g_pwm_inv
    assign pwm_eff = ~syn_in[IX_PWM];
  end else begin : g_pwm_dir
    assign pwm_eff = syn_in[IX_PWM];
  end

  hbg_fsm #(
    .MIN_GAP (MIN_GAP),
    .TIMEOUT (TIMEOUT)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_i     (pwm_eff),
    .en_i      (syn_in[IX_EN]),
    .sync_i    (syn_in[IX_SYNC]),
    .clamp_n_i (syn_in[IX_CLAMP_N]),
    .ls_fb_i   (syn_in[IX_LS_FB]),
    .sw_fb_i   (syn_in[IX_SW_FB]),
    .hs_gate_o (hs_gate_o),
    .ls_gate_o (ls_gate_o),
    .fault_o   (fault_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!hs_gate_o && !ls_gate_o && !fault_o));

endmodule

// File: tb/tb_hb_gate_seq.sv
module tb_hb_gate_seq;

  localparam int GAP = 3;
  localparam int TMO = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, en = 1'b1, sync = 1'b1, clamp_n = 1'b1, ls_fb = 1'b0, sw_fb = 1'b0;
  logic hs, ls, flt;
  logic hs_i, ls_i, flt_i;
  int   total = 0;
  int   bad   = 0;

  always #5 clk = ~clk;

  hb_gate_seq #(.PWM_INVERT(1'b0), .MIN_GAP(GAP), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .en_i(en), .sync_i(sync),
    .clamp_n_i(clamp_n), .ls_fb_i(ls_fb), .sw_fb_i(sw_fb),
    .hs_gate_o(hs), .ls_gate_o(ls), .fault_o(flt));

  hb_gate_seq #(.PWM_INVERT(1'b1), .MIN_GAP(GAP), .TIMEOUT(TMO)) dut_inv (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .en_i(en), .sync_i(sync),
    .clamp_n_i(clamp_n), .ls_fb_i(ls_fb), .sw_fb_i(sw_fb),
    .hs_gate_o(hs_i), .ls_gate_o(ls_i), .fault_o(flt_i));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  // Expected gate level after the inputs have been held steady: 2 = free, else the forced value.
  function automatic int exp_ls(input logic c_n, input logic e, input logic s);
    if (!c_n) return 1;
    if (!e)   return 0;
    if (!s)   return 0;
    return 2;
  endfunction

  function automatic int exp_hs(input logic c_n, input logic e);
    if (!c_n) return 0;
    if (!e)   return 0;
    return 2;
  endfunction

  // Counts the all-off cycles between one gate dropping and the other rising.
  task automatic handover(input string req, input bit to_high);
    int  off = 0;
    bit  seen = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (!seen) begin
        if (to_high ? hs : ls) begin
          seen = 1;
          chk(req, (off == GAP), 1'b1);
        end else if (!hs && !ls) begin
          off++;
        end
      end
    end
    chk(req, seen, 1'b1);
  endtask

  initial begin
    #(150000 * 10);
    total++;
    bad++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    step(2);
    chk("R1 hs in reset", hs, 1'b0);
    chk("R1 ls in reset", ls, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1 fault after reset", flt, 1'b0);
    chk("R1 hs after reset", hs, 1'b0);

    // R5, R7: synchronous mode settles on the lower switch
    step(12);
    chk("R5 ls on with pwm low", ls, 1'b1);
    chk("R5 hs off with pwm low", hs, 1'b0);

    // R8, R6: handover low -> high, then high -> low
    pwm = 1'b1;
    handover("R8 gap low->high", 1'b1);
    pwm = 1'b0;
    handover("R8 gap high->low", 1'b0);

    // R6: upper gate waits for the lower-gate feedback
    ls_fb = 1'b1;
    pwm   = 1'b1;
    step(10);
    chk("R6 hs held while ls_fb high", hs, 1'b0);
    chk("R6 ls off while waiting", ls, 1'b0);
    chk("R10 no fault before limit", flt, 1'b0);
    ls_fb = 1'b0;
    step(6);
    chk("R6 hs on after ls_fb low", hs, 1'b1);

    // R7: lower gate waits for the switch-node feedback
    sw_fb = 1'b1;
    pwm   = 1'b0;
    step(10);
    chk("R7 ls held while sw_fb high", ls, 1'b0);
    chk("R7 hs off while waiting", hs, 1'b0);
    sw_fb = 1'b0;
    step(6);
    chk("R7 ls on after sw_fb low", ls, 1'b1);

    // R10: timeout latches a fault
    pwm = 1'b1;
    step(12);
    chk("R5 hs on with pwm high", hs, 1'b1);
    sw_fb = 1'b1;
    pwm   = 1'b0;
    step(TMO + 8);
    chk("R10 fault set", flt, 1'b1);
    chk("R10 ls off at fault", ls, 1'b0);
    chk("R10 hs off at fault", hs, 1'b0);
    sw_fb = 1'b0;
    pwm   = 1'b1;
    step(10);
    chk("R10 hs stays off", hs, 1'b0);
    pwm = 1'b0;
    step(10);
    chk("R10 ls stays off", ls, 1'b0);
    chk("R10 fault sticky", flt, 1'b1);
    clamp_n = 1'b0;
    step(4);
    chk("R2 clamp over fault ls", ls, 1'b1);
    chk("R2 clamp over fault hs", hs, 1'b0);
    clamp_n = 1'b1;
    step(4);
    chk("R10 ls off after clamp", ls, 1'b0);
    do_reset();
    chk("R1 fault cleared by reset", flt, 1'b0);

    // R4, R9: diode mode and polarity
    sync = 1'b0;
    pwm  = 1'b0;
    do_reset();
    step(12);
    chk("R4 ls off in diode mode", ls, 1'b0);
    chk("R4 hs off pwm low", hs, 1'b0);
    chk("R9 inverted hs on pwm low", hs_i, 1'b1);
    chk("R4 inverted ls off", ls_i, 1'b0);
    pwm = 1'b1;
    step(12);
    chk("R4 hs follows pwm", hs, 1'b1);
    chk("R9 inverted hs off pwm high", hs_i, 1'b0);
    chk("R4 ls still off", ls, 1'b0);

    // R3: enable low
    sync = 1'b1;
    en   = 1'b0;
    step(6);
    chk("R3 hs off disabled", hs, 1'b0);
    chk("R3 ls off disabled", ls, 1'b0);
    pwm = 1'b0;
    step(6);
    chk("R3 ls off disabled pwm low", ls, 1'b0);

    // R2: clamp from the upper state, and with enable low
    en  = 1'b1;
    pwm = 1'b1;
    step(12);
    chk("R5 hs on before clamp", hs, 1'b1);
    clamp_n = 1'b0;
    step(3);
    chk("R2 clamp ls", ls, 1'b1);
    chk("R2 clamp hs", hs, 1'b0);
    en = 1'b0;
    step(4);
    chk("R2 clamp over disable", ls, 1'b1);
    clamp_n = 1'b1;
    en      = 1'b1;
    do_reset();

    // Random phase with a fixed seed
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 300; it++) begin
      int el, eh, el_i, eh_i;
      pwm     = 1'($urandom % 2);
      en      = 1'(($urandom % 8) != 0);
      sync    = 1'($urandom % 2);
      clamp_n = 1'(($urandom % 10) != 0);
      ls_fb   = 1'(($urandom % 12) == 0);
      sw_fb   = 1'(($urandom % 12) == 0);
      for (int c = 0; c < 5; c++) begin
        step(1);
        chk("R11 overlap", hs && ls, 1'b0);
        chk("R11 overlap inv", hs_i && ls_i, 1'b0);
      end
      el = exp_ls(clamp_n, en, sync);
      eh = exp_hs(clamp_n, en);
      el_i = el;
      eh_i = eh;
      if (el != 2)   chk(!clamp_n ? "R2 random ls" : (!en ? "R3 random ls" : "R4 random ls"), ls, 1'(el));
      if (eh != 2)   chk(!clamp_n ? "R2 random hs" : "R3 random hs", hs, 1'(eh));
      if (el_i != 2) chk("R2 random ls inv", ls_i, 1'(el_i));
      if (eh_i != 2) chk("R3 random hs inv", hs_i, 1'(eh_i));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule